// File: doc/BRIEF.md
# Masked Address Watchpoint Comparator

This block is one debug comparator that watches the core's buses. It holds three configuration registers: a reference value, a count of low bits to ignore, and a function word. Every cycle it compares the current instruction address, the current data-bus address or an external cycle count against the reference value, with the low bits below the ignore count cleared on both sides. A qualifying match produces one of three actions on the following cycle: a halt request for the debugger, a trigger pulse for a trace unit, or a sample request to a trace sink. The function code picks the action.

Data accesses carry a size. The comparison uses the aligned byte span of the access, so a reference that points into the middle of a word also catches a word access that covers it. Each match also sets a sticky matched flag in the function register. Reading that register clears the flag. Sample requests respect fault and burst status: a data sample is dropped for a faulting access, and a PC sample tied to a data access is only taken on the first beat of a burst.

Top module: `wpt_comparator`

## Requirements
- R1: Function code 0 disables the comparator. No matching access raises any output, and the matched flag stays 0.
- R2: A data address matches when it equals the reference above bit E, where E is the larger of the ignore count and log2 of the access size. Size encoding is 0 byte, 1 halfword, 2 word. Instruction addresses and the cycle count use the ignore count alone.
- R3: Codes 4, 5, 6 and 7 raise halt_o on an instruction-address match, a data read, a data write, and any data access, respectively.
- R4: Codes 8, 9, 10 and 11 raise trig_o for the same four access kinds as R3.
- R5: The sample codes are as follows. Code 1 gives a PC sample on an instruction-address match. Code 2 gives a data sample on a read or write. Code 3 gives PC and data samples on a read or write. Code 12 gives a data sample on a read. Code 13 gives a data sample on a write. Code 14 gives PC and data samples on a read. Code 15 gives PC and data samples on a write.
- R6: A faulting data access never produces data_sample_o. A PC sample for the same access is still produced.
- R7: For data-source codes, pc_sample_o is produced only when bus_first marks the first beat of a burst.
- R8: When function bit 7 is set, the reference is compared with cycle_count under the ignore count. Only codes 1, 4 and 8 respond in this mode, and all bus addresses are ignored.
- R9: Function bit 24 is the matched flag. It is set by any qualifying match and cleared by a read of the function register. A match in the same cycle as that read leaves the flag set.
- R10: All four action outputs are registered. Each is a one-cycle pulse in the cycle after the access that caused it, and all are 0 after reset.
- R11: The registers are selected as follows: sel 0 is the reference, sel 1 is the ignore count (bits 3:0), sel 2 is the function word (code in bits 3:0, cycle mode in bit 7, flag in bit 24). A read returns the stored fields, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe; a function-register read clears the flag |
| cfg_sel | input | 2 | Register select: 0 reference, 1 ignore count, 2 function |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the selected register (combinational) |
| if_valid | input | 1 | Instruction address valid |
| if_addr | input | AW | Instruction address |
| bus_valid | input | 1 | Data access valid |
| bus_addr | input | AW | Data access address |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_fault | input | 1 | Access faults |
| bus_first | input | 1 | First beat of a burst |
| cycle_count | input | AW | External cycle counter |
| halt_o | output | 1 | Watchpoint halt pulse |
| trig_o | output | 1 | Trace trigger pulse |
| pc_sample_o | output | 1 | PC sample request pulse |
| data_sample_o | output | 1 | Data sample request pulse |

## Verification
The bound checker examines every cycle. It checks that a disabled comparator stays silent, that no data sample follows a faulting access, and that the halt, trigger and sample classes never fire together. It also checks that a match always leaves the flag set, that a read with no concurrent match leaves it clear, and that a halt only follows a watchpoint code. The span-aware address compare, the exact mapping of each function code, burst-beat gating and cycle-count mode depend on chosen values and access sequences. Only the bench's scoreboard scenarios show these, by comparing every cycle's outputs against a model built from the requirements.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

   localparam int REG_W    = 32;
   localparam int FLAG_BIT = 24;
   localparam int CYCM_BIT = 7;

   localparam logic [1:0] SEL_REF  = 2'd0;
   localparam logic [1:0] SEL_IGN  = 2'd1;
   localparam logic [1:0] SEL_FUNC = 2'd2;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PC   = 2'd1,
      SRC_DATA = 2'd2
   } src_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_HALT   = 2'd1,
      ACT_TRIG   = 2'd2,
      ACT_SAMPLE = 2'd3
   } act_e;

   typedef struct packed {
      src_e src;
      act_e act;
      logic on_rd;
      logic on_wr;
      logic pc_smp;
      logic dat_smp;
   } fdec_t;

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
   import wpt_pkg::*;
#(
   parameter int AW    = 32,
   parameter int MASKW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              hit,
   output logic [AW-1:0]     ref_q,
   output logic [MASKW-1:0]  ign_q,
   output logic [3:0]        code_q,
   output logic              cycm_q,
   output logic              flag_q,
   output logic [REG_W-1:0]  cfg_rdata
);

   logic rd_func;
   logic wdata_unused;

   assign rd_func      = cfg_re && (cfg_sel == SEL_FUNC);
   assign wdata_unused = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         ign_q  <= '0;
         code_q <= '0;
         cycm_q <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_REF:  ref_q <= cfg_wdata[AW-1:0];
            SEL_IGN:  ign_q <= cfg_wdata[MASKW-1:0];
            SEL_FUNC: begin
               code_q <= cfg_wdata[3:0];
               cycm_q <= cfg_wdata[CYCM_BIT];
            end
            default: ;
         endcase
      end
   end

   // a new match outranks the clear of a concurrent read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (hit)     flag_q <= 1'b1;
      else if (rd_func) flag_q <= 1'b0;
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_sel)
         SEL_REF:  cfg_rdata = REG_W'(ref_q);
         SEL_IGN:  cfg_rdata = REG_W'(ign_q);
         SEL_FUNC: begin
            cfg_rdata[3:0]      = code_q;
            cfg_rdata[CYCM_BIT] = cycm_q;
            cfg_rdata[FLAG_BIT] = flag_q;
         end
         default: cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/wpt_func_decode.sv
module wpt_func_decode
   import wpt_pkg::*;
(
   input  logic [3:0] code,
   output fdec_t      dec
);

   always_comb begin
      dec = '{src: SRC_NONE, act: ACT_NONE, on_rd: 1'b0, on_wr: 1'b0,
              pc_smp: 1'b0, dat_smp: 1'b0};
      case (code[3:2])
         2'b01, 2'b10: begin
            dec.act   = (code[3:2] == 2'b01) ? ACT_HALT : ACT_TRIG;
            dec.src   = (code[1:0] == 2'b00) ? SRC_PC : SRC_DATA;
            dec.on_rd = code[0];
            dec.on_wr = code[1];
         end
         2'b00: begin
            if (code[1:0] != 2'b00) begin
               dec.act = ACT_SAMPLE;
               if (code[1:0] == 2'b01) begin
                  dec.src    = SRC_PC;
                  dec.pc_smp = 1'b1;
               end else begin
                  dec.src     = SRC_DATA;
                  dec.on_rd   = 1'b1;
                  dec.on_wr   = 1'b1;
                  dec.dat_smp = 1'b1;
                  dec.pc_smp  = code[0];
               end
            end
         end
         default: begin
            dec.act     = ACT_SAMPLE;
            dec.src     = SRC_DATA;
            dec.on_rd   = ~code[0];
            dec.on_wr   = code[0];
            dec.dat_smp = 1'b1;
            dec.pc_smp  = code[1];
         end
      endcase
   end

endmodule

// File: rtl/wpt_mask_match.sv
module wpt_mask_match #(
   parameter int AW         = 32,
   parameter int MASKW      = 4,
   parameter bit SPAN_AWARE = 1'b0
) (
   input  logic [AW-1:0]    addr,
   input  logic [AW-1:0]    ref_val,
   input  logic [MASKW-1:0] ign,
   input  logic [1:0]       size,
   output logic             hit
);

   logic [MASKW-1:0] eff;
   logic [AW-1:0]    keep;

   generate
      if (SPAN_AWARE) begin : g_span
         logic [MASKW-1:0] span_lg;
         always_comb begin
            case (size)
               2'd0:    span_lg = MASKW'(0);
               2'd1:    span_lg = MASKW'(1);
               default: span_lg = MASKW'(2);
            endcase
            eff = (ign > span_lg) ? ign : span_lg;
         end
      end else begin : g_plain
         logic size_unused;
         assign size_unused = ^size;
         assign eff = ign;
      end
   endgenerate

   assign keep = {AW{1'b1}} << eff;
   assign hit  = ((addr ^ ref_val) & keep) == '0;

endmodule

// File: rtl/wpt_comparator.sv
module wpt_comparator
   import wpt_pkg::*;
#(
   parameter int AW    = 32,
   parameter int MASKW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_re,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              if_valid,
   input  logic [AW-1:0]     if_addr,
   input  logic              bus_valid,
   input  logic [AW-1:0]     bus_addr,
   input  logic              bus_write,
   input  logic [1:0]        bus_size,
   input  logic              bus_fault,
   input  logic              bus_first,
   input  logic [AW-1:0]     cycle_count,
   output logic              halt_o,
   output logic              trig_o,
   output logic              pc_sample_o,
   output logic              data_sample_o
);

   localparam int MAX_IGN = (1 << MASKW) - 1;

   if (AW < 8 || AW > REG_W) begin : g_bad_aw
      $error("wpt_comparator: AW must lie in 8..32");
   end
   if (MAX_IGN >= AW) begin : g_bad_maskw
      $error("wpt_comparator: MASKW allows ignoring every address bit");
   end

   logic [AW-1:0]    ref_q;
   logic [MASKW-1:0] ign_q;
   logic [3:0]       fcode;
   logic             cycm;
   logic             flag;
   fdec_t            fd;
   logic             pc_m, bus_m, cyc_m;
   logic             pc_hit, d_hit, dir_ok, hit;
   logic             halt_d, trig_d, pcs_d, dts_d;

   wpt_regs #(.AW(AW), .MASKW(MASKW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .hit(hit),
      .ref_q(ref_q), .ign_q(ign_q), .code_q(fcode), .cycm_q(cycm),
      .flag_q(flag), .cfg_rdata(cfg_rdata)
   );

   wpt_func_decode u_dec (.code(fcode), .dec(fd));

   wpt_mask_match #(.AW(AW), .MASKW(MASKW), .SPAN_AWARE(1'b0)) u_pc_cmp (
      .addr(if_addr), .ref_val(ref_q), .ign(ign_q), .size(2'd0), .hit(pc_m)
   );
   wpt_mask_match #(.AW(AW), .MASKW(MASKW), .SPAN_AWARE(1'b1)) u_bus_cmp (
      .addr(bus_addr), .ref_val(ref_q), .ign(ign_q), .size(bus_size), .hit(bus_m)
   );
   wpt_mask_match #(.AW(AW), .MASKW(MASKW), .SPAN_AWARE(1'b0)) u_cyc_cmp (
      .addr(cycle_count), .ref_val(ref_q), .ign(ign_q), .size(2'd0), .hit(cyc_m)
   );

   always_comb begin
      pc_hit = cycm ? cyc_m : (if_valid && pc_m);
      dir_ok = bus_write ? fd.on_wr : fd.on_rd;
      d_hit  = !cycm && bus_valid && bus_m && dir_ok;
      hit    = ((fd.src == SRC_PC) && pc_hit) || ((fd.src == SRC_DATA) && d_hit);
      halt_d = hit && (fd.act == ACT_HALT);
      trig_d = hit && (fd.act == ACT_TRIG);
      pcs_d  = hit && (fd.act == ACT_SAMPLE) && fd.pc_smp &&
               ((fd.src == SRC_PC) || bus_first);
      dts_d  = hit && (fd.act == ACT_SAMPLE) && fd.dat_smp && !bus_fault;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_o        <= 1'b0;
         trig_o        <= 1'b0;
         pc_sample_o   <= 1'b0;
         data_sample_o <= 1'b0;
      end else begin
         halt_o        <= halt_d;
         trig_o        <= trig_d;
         pc_sample_o   <= pcs_d;
         data_sample_o <= dts_d;
      end
   end

endmodule

// File: rtl/wpt_comparator_chk.sv
module wpt_comparator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_re,
   input logic [1:0] cfg_sel,
   input logic       bus_fault,
   input logic [3:0] fcode,
   input logic       hit,
   input logic       flag,
   input logic       halt_o,
   input logic       trig_o,
   input logic       pc_sample_o,
   input logic       data_sample_o
);

   p_off_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fcode) == 4'd0 |-> !(halt_o || trig_o || pc_sample_o || data_sample_o));

   p_halt_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_o |-> ($past(fcode) >= 4'd4 && $past(fcode) <= 4'd7));

   p_fault_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_sample_o |-> !$past(bus_fault));

   p_set_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_re && cfg_sel == 2'd2 && !hit) |=> !flag);

   p_one_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({halt_o, trig_o, pc_sample_o || data_sample_o}));

endmodule

bind wpt_comparator wpt_comparator_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_re(cfg_re), .cfg_sel(cfg_sel),
   .bus_fault(bus_fault), .fcode(fcode), .hit(hit), .flag(flag),
   .halt_o(halt_o), .trig_o(trig_o), .pc_sample_o(pc_sample_o),
   .data_sample_o(data_sample_o)
);

// File: tb/wpt_comparator_test.sv
module wpt_comparator_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_re = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        if_valid = 1'b0;
   logic [31:0] if_addr = '0;
   logic        bus_valid = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_write = 1'b0;
   logic [1:0]  bus_size = 2'd0;
   logic        bus_fault = 1'b0, bus_first = 1'b0;
   logic [31:0] cycle_count = '0;
   logic        halt_o, trig_o, pc_sample_o, data_sample_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_n = 0;

   typedef struct {
      int         due;
      logic [3:0] exp;
      string      req;
   } item_t;
   item_t sb[$];

   // shadow configuration, written by the driver only
   logic [31:0] sh_ref = '0;
   logic [3:0]  sh_ign = '0;
   logic [3:0]  sh_code = '0;
   logic        sh_cycm = 1'b0;
   logic        sh_flag = 1'b0;

   wpt_comparator uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .if_valid(if_valid), .if_addr(if_addr), .bus_valid(bus_valid),
      .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
      .bus_fault(bus_fault), .bus_first(bus_first), .cycle_count(cycle_count),
      .halt_o(halt_o), .trig_o(trig_o), .pc_sample_o(pc_sample_o),
      .data_sample_o(data_sample_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc_n <= cyc_n + 1;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pop items whose result is due in this cycle
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0 && sb[0].due == cyc_n) begin
            item_t it;
            it = sb.pop_front();
            check(it.req, {28'd0, halt_o, trig_o, pc_sample_o, data_sample_o},
                  {28'd0, it.exp});
         end
      end
   end

   function automatic logic masked_eq(logic [31:0] a, logic [31:0] b, int lo);
      logic [31:0] keep;
      keep = 32'hFFFF_FFFF << lo;
      return ((a ^ b) & keep) == 32'd0;
   endfunction

   // one cycle of stimulus; expected outputs follow the requirement text
   task automatic step(bit iv, logic [31:0] ia, bit dv, logic [31:0] da, bit dw,
                       logic [1:0] sz, bit flt, bit first, logic [31:0] cc,
                       bit rd, string req);
      int   szl, eff;
      bit   src_pc, src_d, on_rd, on_wr, halt_c, trig_c, samp_c, ps, ds;
      bit   pc_hit, d_hit, hit;
      logic [3:0] exp;
      @(posedge clk); #2;
      cfg_we = 1'b0; cfg_re = rd; cfg_sel = 2'd2; cfg_wdata = '0;
      if_valid = iv; if_addr = ia; bus_valid = dv; bus_addr = da;
      bus_write = dw; bus_size = sz; bus_fault = flt; bus_first = first;
      cycle_count = cc;
      src_pc = 0; src_d = 0; on_rd = 0; on_wr = 0;
      halt_c = 0; trig_c = 0; samp_c = 0; ps = 0; ds = 0;
      case (sh_code)
         4'd1:  begin samp_c = 1; src_pc = 1; ps = 1; end
         4'd2:  begin samp_c = 1; src_d = 1; on_rd = 1; on_wr = 1; ds = 1; end
         4'd3:  begin samp_c = 1; src_d = 1; on_rd = 1; on_wr = 1; ds = 1; ps = 1; end
         4'd4:  begin halt_c = 1; src_pc = 1; end
         4'd5:  begin halt_c = 1; src_d = 1; on_rd = 1; end
         4'd6:  begin halt_c = 1; src_d = 1; on_wr = 1; end
         4'd7:  begin halt_c = 1; src_d = 1; on_rd = 1; on_wr = 1; end
         4'd8:  begin trig_c = 1; src_pc = 1; end
         4'd9:  begin trig_c = 1; src_d = 1; on_rd = 1; end
         4'd10: begin trig_c = 1; src_d = 1; on_wr = 1; end
         4'd11: begin trig_c = 1; src_d = 1; on_rd = 1; on_wr = 1; end
         4'd12: begin samp_c = 1; src_d = 1; on_rd = 1; ds = 1; end
         4'd13: begin samp_c = 1; src_d = 1; on_wr = 1; ds = 1; end
         4'd14: begin samp_c = 1; src_d = 1; on_rd = 1; ds = 1; ps = 1; end
         4'd15: begin samp_c = 1; src_d = 1; on_wr = 1; ds = 1; ps = 1; end
         default: ;
      endcase
      szl = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
      eff = (int'(sh_ign) > szl) ? int'(sh_ign) : szl;
      pc_hit = sh_cycm ? masked_eq(cc, sh_ref, int'(sh_ign))
                       : (iv && masked_eq(ia, sh_ref, int'(sh_ign)));
      d_hit  = !sh_cycm && dv && masked_eq(da, sh_ref, eff) && (dw ? on_wr : on_rd);
      hit    = (src_pc && pc_hit) || (src_d && d_hit);
      exp[3] = hit && halt_c;
      exp[2] = hit && trig_c;
      exp[1] = hit && samp_c && ps && (src_pc || first);
      exp[0] = hit && samp_c && ds && !flt;
      sb.push_back('{due: cyc_n + 1, exp: exp, req: req});
      if (rd) begin
         #1;
         check({req, " R9 flag read"}, {31'd0, cfg_rdata[24]}, {31'd0, sh_flag});
         sh_flag = hit;
      end else begin
         sh_flag = sh_flag || hit;
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_re = 1'b0; cfg_sel = sel; cfg_wdata = d;
      if_valid = 0; bus_valid = 0; bus_fault = 0; bus_first = 0;
      cycle_count = 32'hFFFF_0000;
      sb.push_back('{due: cyc_n + 1, exp: 4'd0, req: "R10 idle"});
      case (sel)
         2'd0: sh_ref = d;
         2'd1: sh_ign = d[3:0];
         2'd2: begin sh_code = d[3:0]; sh_cycm = d[7]; end
         default: ;
      endcase
   endtask

   task automatic dacc(logic [31:0] a, bit w, logic [1:0] sz, bit flt, bit first,
                       string req);
      step(0, 32'hFFFF_FFF0, 1, a, w, sz, flt, first, 32'hFFFF_0000, 0, req);
   endtask

   task automatic pacc(logic [31:0] a, string req);
      step(1, a, 0, 32'hFFFF_FFF0, 0, 2'd2, 0, 0, 32'hFFFF_0000, 0, req);
   endtask

   task automatic rdflag(string req);
      step(0, 0, 0, 32'hFFFF_FFF0, 0, 2'd2, 0, 0, 32'hFFFF_0000, 1, req);
   endtask

   task automatic rdreg(logic [1:0] sel, logic [31:0] exp, string req);
      @(posedge clk); #2;
      cfg_we = 0; cfg_re = (sel != 2'd2); cfg_sel = sel;
      if_valid = 0; bus_valid = 0; cycle_count = 32'hFFFF_0000;
      sb.push_back('{due: cyc_n + 1, exp: 4'd0, req: "R10 idle"});
      #1;
      check(req, cfg_rdata, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R10 reset outputs", {28'd0, halt_o, trig_o, pc_sample_o, data_sample_o}, 32'd0);
      cfg_sel = 2'd2; #1;
      check("R11 reset function reg", cfg_rdata, 32'd0);
      rst_n = 1'b1;

      // R1: disabled comparator
      wr(2'd0, 32'h0000_1000);
      dacc(32'h1000, 0, 2'd2, 0, 1, "R1 disabled read");
      pacc(32'h1000, "R1 disabled pc");
      rdflag("R1 flag stays clear");

      // R3 watchpoints
      wr(2'd2, 32'd5);
      dacc(32'h1000, 0, 2'd2, 0, 1, "R3 halt on read");
      dacc(32'h1000, 1, 2'd2, 0, 1, "R3 read-only ignores write");
      wr(2'd2, 32'd6);
      dacc(32'h1000, 1, 2'd2, 0, 1, "R3 halt on write");
      dacc(32'h1000, 0, 2'd2, 0, 1, "R3 write-only ignores read");
      wr(2'd2, 32'd7);
      dacc(32'h1000, 0, 2'd2, 0, 1, "R3 rw read");
      dacc(32'h1000, 1, 2'd2, 0, 1, "R3 rw write back-to-back R10");
      wr(2'd2, 32'd4);
      pacc(32'h1000, "R3 halt on pc");
      pacc(32'h1004, "R3 pc mismatch");

      // R11 readback
      rdreg(2'd0, 32'h0000_1000, "R11 reference readback");
      wr(2'd1, 32'hFFFF_FFF3);
      rdreg(2'd1, 32'h0000_0003, "R11 ignore readback");
      wr(2'd2, 32'hFFFF_FF7B);
      rdreg(2'd2, 32'h0000_000B | (sh_flag ? 32'h0100_0000 : 32'h0), "R11 function readback");

      // R2 masking
      wr(2'd0, 32'h0000_2000); wr(2'd1, 32'd8); wr(2'd2, 32'd7);
      dacc(32'h20FC, 0, 2'd0, 0, 1, "R2 inside ignored bits");
      dacc(32'h2100, 0, 2'd0, 0, 1, "R2 outside ignored bits");
      // R2 access span
      wr(2'd0, 32'd3); wr(2'd1, 32'd0);
      dacc(32'h0, 0, 2'd2, 0, 1, "R2 word covers byte 3");
      dacc(32'h0, 0, 2'd0, 0, 1, "R2 byte 0 misses 3");
      dacc(32'h2, 0, 2'd1, 0, 1, "R2 halfword covers byte 3");
      dacc(32'h0, 0, 2'd1, 0, 1, "R2 halfword misses 3");

      // R4 trace triggers
      wr(2'd0, 32'h0000_4000);
      wr(2'd2, 32'd8);  pacc(32'h4000, "R4 trig pc");
      wr(2'd2, 32'd9);  dacc(32'h4000, 0, 2'd2, 0, 1, "R4 trig read");
                        dacc(32'h4000, 1, 2'd2, 0, 1, "R4 trig read ignores write");
      wr(2'd2, 32'd10); dacc(32'h4000, 1, 2'd2, 0, 1, "R4 trig write");
      wr(2'd2, 32'd11); dacc(32'h4000, 0, 2'd2, 0, 1, "R4 trig rw");

      // R5 / R6 / R7 samples
      wr(2'd0, 32'h0000_3000); wr(2'd1, 32'd2);
      wr(2'd2, 32'd2);
      dacc(32'h3000, 0, 2'd2, 0, 1, "R5 data sample");
      dacc(32'h3000, 1, 2'd2, 1, 1, "R6 faulting data sample dropped");
      wr(2'd2, 32'd14);
      dacc(32'h3000, 0, 2'd2, 1, 1, "R6 pc sample kept on fault");
      dacc(32'h3000, 0, 2'd2, 0, 0, "R7 later beat no pc sample");
      dacc(32'h3000, 1, 2'd2, 0, 1, "R5 code 14 ignores write");
      wr(2'd2, 32'd15);
      dacc(32'h3000, 1, 2'd2, 0, 1, "R5 pc and data on write");
      wr(2'd2, 32'd12);
      dacc(32'h3000, 1, 2'd2, 0, 1, "R5 code 12 ignores write");
      dacc(32'h3000, 0, 2'd2, 0, 1, "R5 code 12 read sample");
      wr(2'd2, 32'd13);
      dacc(32'h3000, 1, 2'd2, 0, 1, "R5 code 13 write sample");
      wr(2'd2, 32'd3);
      dacc(32'h3000, 0, 2'd2, 0, 1, "R5 code 3 both samples");
      dacc(32'h3000, 1, 2'd2, 0, 0, "R7 code 3 later beat");
      wr(2'd2, 32'd1);
      pacc(32'h3002, "R5 pc sample on instruction");

      // R8 cycle-count mode
      wr(2'd0, 32'h55); wr(2'd1, 32'd0); wr(2'd2, 32'h84);
      step(0, 0, 0, 0, 0, 2'd2, 0, 0, 32'h55, 0, "R8 cycle equal halts");
      step(1, 32'h55, 0, 0, 0, 2'd2, 0, 0, 32'h0, 0, "R8 pc ignored in cycle mode");
      wr(2'd1, 32'd4);
      step(0, 0, 0, 0, 0, 2'd2, 0, 0, 32'h5A, 0, "R8 cycle masked match");
      wr(2'd2, 32'h85);
      step(0, 0, 1, 32'h55, 0, 2'd2, 0, 1, 32'h55, 0, "R8 data code silent");

      // R9 sticky flag
      wr(2'd0, 32'h0000_1000); wr(2'd1, 32'd0); wr(2'd2, 32'd5);
      rdflag("R9 clear stale");
      dacc(32'h1000, 0, 2'd2, 0, 1, "R9 hit sets flag");
      rdflag("R9 read sees set");
      rdflag("R9 read sees cleared");
      step(0, 0, 1, 32'h1000, 0, 2'd2, 0, 1, 32'hFFFF_0000, 1, "R9 hit with read");
      rdflag("R9 flag kept after concurrent read");

      repeat (4) @(posedge clk);
      #3;
      check("R10 scoreboard drained", sb.size(), 32'd0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule